// File: doc/BRIEF.md
# Multi-Precision Boxing and Sign-Injection Unit

This combinational unit sits next to a 128-bit floating-point register file whose entries hold single, double or quad precision values. A narrower value stored in a wide entry must carry all ones above it; the unit checks that, extracts the narrow value, and puts the canonical NaN of that precision in its place when the ones are missing. The upper part of the check is shared across precisions. A single-precision value is well formed only when the entry is also a well-formed double box, and its bits 63:32 are all ones as well.

On the same path the unit applies one of three sign injections or a plain sign flip at the selected precision. It then boxes the result back into 128 bits, ready for write-back. A pass operation only unboxes and reboxes operand A. Operand A's boxing status at the selected precision is reported on a separate output. Rounding, exception flags and the register storage are not part of this unit.

Top module: `fp_box_sgnj`

## Requirements
- R1: With `prec_i`=1 (double), operand A counts as well formed only when A[127:64] are all ones; `a_ok_o` reports this, and a pass (`op_i`=0) of a well-formed A returns A unchanged.
- R2: With `prec_i`=0 (single), operand A counts as well formed only when A[127:32] are all ones, meaning it must also be a well-formed double box.
- R3: An operand that is not well formed at the selected precision is used as the canonical NaN of that precision: 0x7FC00000 for single and 0x7FF8000000000000 for double.
- R4: A single-precision result has bits 127:32 set to one. A double-precision result has bits 127:64 set to one.
- R5: With `prec_i`=2 or 3 (quad), operands are used as stored, with no boxing check, and `a_ok_o` is 1.
- R6: With `op_i`=1, the result takes the sign from operand B and every other bit from operand A.
- R7: With `op_i`=2, the result takes the inverse of B's sign and every other bit from operand A.
- R8: With `op_i`=3, the result's sign is A's sign xor B's sign, and every other bit comes from operand A.
- R9: The sign bit is bit 31 for single, bit 63 for double and bit 127 for quad. The injections change only that bit of the unboxed value.
- R10: With `op_i`=4, the result is operand A with only its sign bit inverted. At quad this is bit 127.
- R11: Values of `op_i` from 5 to 7 behave like the pass operation `op_i`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 128 | Operand A as stored in the register file |
| b_i | input | 128 | Operand B (sign source) as stored |
| prec_i | input | 2 | 0 single, 1 double, 2 or 3 quad |
| op_i | input | 3 | 0 pass, 1 copy sign, 2 inverted sign, 3 xor sign, 4 flip sign, 5-7 pass |
| res_o | output | 128 | Boxed 128-bit result |
| a_ok_o | output | 1 | Operand A is well formed at the selected precision |

## Verification
The case that matters most is the NaN substitution and the sign injection acting in the same evaluation. A badly boxed operand A must first become the canonical NaN. That NaN must then take its sign from B, whose own boxing may also be invalid. The bench provokes this with random operands whose upper bits are all ones only about half of the time, across all operations and precisions, plus directed cases with a broken box in the double half of a single operand. It judges each result against a reference function that unboxes, injects and reboxes on its own slices.

// File: rtl/fp_box_sgnj.sv
module fp_box_sgnj (
  input  logic [127:0] a_i,
  input  logic [127:0] b_i,
  input  logic [1:0]   prec_i,
  input  logic [2:0]   op_i,
  output logic [127:0] res_o,
  output logic         a_ok_o
);
  localparam logic [31:0]  NAN_S = 32'h7FC0_0000;
  localparam logic [63:0]  NAN_D = 64'h7FF8_0000_0000_0000;
  localparam logic [1:0]   P_S = 2'd0;
  localparam logic [1:0]   P_D = 2'd1;

  logic a_dbl, a_sgl, b_dbl, b_sgl;
  logic [127:0] ua, ub, mask, r;
  logic sa, sb, ns;

  assign a_dbl = &a_i[127:64];
  assign a_sgl = a_dbl & (&a_i[63:32]);
  assign b_dbl = &b_i[127:64];
  assign b_sgl = b_dbl & (&b_i[63:32]);

  always_comb begin
    case (prec_i)
      P_S: begin
        ua     = {96'b0, a_sgl ? a_i[31:0] : NAN_S};
        ub     = {96'b0, b_sgl ? b_i[31:0] : NAN_S};
        mask   = 128'h1 << 31;
        a_ok_o = a_sgl;
      end
      P_D: begin
        ua     = {64'b0, a_dbl ? a_i[63:0] : NAN_D};
        ub     = {64'b0, b_dbl ? b_i[63:0] : NAN_D};
        mask   = 128'h1 << 63;
        a_ok_o = a_dbl;
      end
      default: begin
        ua     = a_i;
        ub     = b_i;
        mask   = 128'h1 << 127;
        a_ok_o = 1'b1;
      end
    endcase
  end

  assign sa = |(ua & mask);
  assign sb = |(ub & mask);

  always_comb begin
    case (op_i)
      3'd1:    ns = sb;
      3'd2:    ns = ~sb;
      3'd3:    ns = sa ^ sb;
      3'd4:    ns = ~sa;
      default: ns = sa;
    endcase
    r = (ua & ~mask) | (ns ? mask : 128'b0);
    case (prec_i)
      P_S:     res_o = {{96{1'b1}}, r[31:0]};
      P_D:     res_o = {{64{1'b1}}, r[63:0]};
      default: res_o = r;
    endcase
  end

  always_comb begin
    if (prec_i == P_D && op_i == 3'd0 && (&a_i[127:64]))
      AST_DBL_PASS: assert (res_o == a_i) else $error("double pass altered value"); // R1
    if (prec_i == P_S && a_ok_o)
      AST_SGL_NEST: assert (&a_i[127:64]) else $error("single ok without double box"); // R2
    if (prec_i == P_S && !a_ok_o && op_i == 3'd0)
      AST_NAN_SGL: assert (res_o[31:0] == NAN_S) else $error("missing single NaN"); // R3
    if (prec_i == P_S)
      AST_BOX_SGL: assert (&res_o[127:32]) else $error("single result unboxed"); // R4
    if (prec_i[1])
      AST_QUAD_BODY: assert (res_o[126:0] == a_i[126:0] && a_ok_o) else $error("quad body changed"); // R5
    if (prec_i[1] && op_i == 3'd4)
      AST_QUAD_FLIP: assert (res_o[127] != a_i[127]) else $error("quad flip"); // R10
  end
endmodule

// File: tb/test_fp_box_sgnj.sv
module test_fp_box_sgnj;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [127:0] a, b, res;
  logic [1:0]   prec;
  logic [2:0]   op;
  logic         a_ok;
  int checks = 0, fails = 0;

  fp_box_sgnj i_fp_box_sgnj (.a_i(a), .b_i(b), .prec_i(prec), .op_i(op), .res_o(res), .a_ok_o(a_ok));

  function automatic logic ok_at(logic [127:0] v, logic [1:0] p);
    if (p == 2'd0) return v[127:32] == {96{1'b1}};
    if (p == 2'd1) return v[127:64] == {64{1'b1}};
    return 1'b1;
  endfunction

  function automatic logic [127:0] expect_res(logic [127:0] x, logic [127:0] y, logic [1:0] p, logic [2:0] o);
    logic sx, sy, s;
    logic [31:0] xs, ys;
    logic [63:0] xd, yd;
    xs = ok_at(x, 2'd0) ? x[31:0] : 32'h7FC00000;
    ys = ok_at(y, 2'd0) ? y[31:0] : 32'h7FC00000;
    xd = ok_at(x, 2'd1) ? x[63:0] : 64'h7FF8000000000000;
    yd = ok_at(y, 2'd1) ? y[63:0] : 64'h7FF8000000000000;
    sx = (p == 2'd0) ? xs[31] : (p == 2'd1) ? xd[63] : x[127];
    sy = (p == 2'd0) ? ys[31] : (p == 2'd1) ? yd[63] : y[127];
    case (o)
      3'd1: s = sy;
      3'd2: s = !sy;
      3'd3: s = sx ^ sy;
      3'd4: s = !sx;
      default: s = sx;
    endcase
    if (p == 2'd0) return {{96{1'b1}}, s, xs[30:0]};
    if (p == 2'd1) return {{64{1'b1}}, s, xd[62:0]};
    return {s, x[126:0]};
  endfunction

  task automatic run(input logic [127:0] x, input logic [127:0] y, input logic [1:0] p,
                     input logic [2:0] o, input string tag);
    logic [127:0] er;
    logic eo;
    @(negedge clk);
    a = x; b = y; prec = p; op = o;
    #2;
    er = expect_res(x, y, p, o);
    eo = ok_at(x, p);
    checks++;
    if (res !== er || a_ok !== eo) begin
      fails++;
      $display("FAIL %s res=%h ok=%b expected res=%h ok=%b", tag, res, a_ok, er, eo);
    end
  endtask

  function automatic logic [127:0] rnd_op(int kind);
    logic [127:0] v;
    v = {$urandom, $urandom, $urandom, $urandom};
    if (kind == 0) v[127:32] = {96{1'b1}};
    else if (kind == 1) v[127:64] = {64{1'b1}};
    else if (kind == 2) begin v[127:32] = {96{1'b1}}; v[40] = 1'b0; end
    return v;
  endfunction

  localparam logic [127:0] ONES = {128{1'b1}};

  initial begin
    #(2_000_000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    a = '0; b = '0; prec = 2'd0; op = 3'd0;
    // Reset-like idle state: zero operands read as single give NaN
    run('0, '0, 2'd0, 3'd0, "R3 idle zero");
    run({{64{1'b1}}, 64'h3FF0000000000000}, '0, 2'd1, 3'd0, "R1 double pass");
    run({64'h0FFFFFFFFFFFFFFF, 64'h3FF0000000000000}, '0, 2'd1, 3'd0, "R1 broken double box");
    run({{64{1'b1}}, 32'hFFFFFFFE, 32'h3F800000}, '0, 2'd0, 3'd0, "R2 broken mid word");
    run({{63{1'b1}}, 1'b0, {32{1'b1}}, 32'h3F800000}, '0, 2'd0, 3'd0, "R2 broken double part");
    run({{96{1'b1}}, 32'h3F800000}, '0, 2'd0, 3'd1, "R3 single NaN sign from B");
    run('0, ONES, 2'd0, 3'd1, "R3 bad A with negative B");
    run({{96{1'b1}}, 32'h00000005}, '0, 2'd1, 3'd0, "R4 single as double box");
    run({64'h1234, 64'h5}, {64'h9, 64'h8000000000000000}, 2'd2, 3'd1, "R5 quad unchecked");
    run({64'h1234, 64'h5}, '0, 2'd3, 3'd0, "R5 quad prec3");
    run({{96{1'b1}}, 32'hBF800000}, {{96{1'b1}}, 32'h00000000}, 2'd0, 3'd1, "R6 copy sign");
    run({{64{1'b1}}, 64'h4000000000000000}, {{64{1'b1}}, 64'h4000000000000000}, 2'd1, 3'd2, "R7 inverted sign");
    run({1'b1, 127'h5}, {1'b1, 127'h0}, 2'd2, 3'd3, "R8 xor sign");
    run({{96{1'b1}}, 32'h7FFFFFFF}, {{96{1'b1}}, 32'h80000000}, 2'd0, 3'd3, "R9 single sign bit 31");
    run({1'b0, 127'h7FFF8 << 108}, '0, 2'd2, 3'd4, "R10 quad flip");
    run({{64{1'b1}}, 64'h1}, '0, 2'd1, 3'd4, "R10 double flip");
    run({{96{1'b1}}, 32'hC0000000}, ONES, 2'd0, 3'd5, "R11 op5");
    run({64'h0, 64'h1}, ONES, 2'd1, 3'd7, "R11 op7");
    for (int i = 0; i < 3000; i++) begin
      logic [127:0] x, y;
      logic [1:0] p;
      logic [2:0] o;
      x = rnd_op($urandom_range(0, 3));
      y = rnd_op($urandom_range(0, 3));
      p = 2'($urandom_range(0, 3));
      o = 3'($urandom_range(0, 7));
      run(x, y, p, o, (o == 3'd1) ? "R6 random" : (o == 3'd2) ? "R7 random" :
                      (o == 3'd3) ? "R8 random" : (o == 3'd4) ? "R10 random" : "R9 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule